// File: doc/BRIEF.md
# Coherent-Port Write Hazard Monitor

This block sits in-line on the write half of an AXI link, between a master and a cache-coherent slave port with a 64-bit data path. The address and data channels are forwarded unchanged. The block looks for write bursts that can damage CPU first-level cache lines. Such a burst is a four-beat, eight-bytes-per-beat burst in which any beat has an incomplete byte strobe. The block also looks for exclusive or locked accesses, which the coherent port does not allow. A flagged burst still reaches the slave intact. The master learns about it only through an error write response, and software learns about it through a sticky interrupt.

Each accepted address gets a slot in a four-entry in-order tracking queue. The burst's verdict is written into that slot when its last data beat is accepted, and the slot is freed on the write-response handshake.

All three channels use valid/ready handshakes. Back-pressure works as follows:
- The address channel stalls, with both the upstream ready and the downstream valid low, while four bursts are outstanding.
- A data beat is only offered downstream once the address of its burst has been accepted.
- A response is only offered upstream once the data of its burst is complete.

Outside these rules, each ready comes straight from the opposite side.

Top module: `coh_wr_guard`

## Requirements
- R1: Address fields (id, address, length, size, burst, lock) and data fields (data, strobe, last) leave on the downstream side equal to the values presented upstream.
- R2: With detection enabled, a burst with length code 3 (four beats) and size code 3 (eight bytes) in which any beat's strobe differs from 8'hFF returns write response 2'b10 upstream, whatever the slave answered.
- R3: A burst of any other length or size code returns the slave's response unchanged, even when its strobes are partial. A four-beat, eight-byte burst with all strobes 8'hFF also returns the slave's response unchanged.
- R4: With detection enabled, lock code 2'b01 (exclusive) or 2'b10 (locked) returns write response 2'b10 for any length, size or strobe.
- R5: The response id equals the slave's response id. A clean burst's response, including 2'b01, is passed unchanged.
- R6: With detection disabled, every response equals the slave's response and the interrupt stays low.
- R7: The interrupt is a sticky level. It rises the cycle after the last beat of a flagged burst is accepted and stays high until cleared.
- R8: A one-cycle pulse on the clear input drops the interrupt on the following cycle. If a new flagged last beat is accepted in the same cycle as the clear, the interrupt stays high.
- R9: While four bursts are outstanding, the upstream address ready and the downstream address valid are both low.
- R10: Data beats are not accepted before their burst's address has been accepted. A response is not offered upstream before its burst's data is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Detection enable |
| irq_clr | input | 1 | One-cycle interrupt clear |
| irq | output | 1 | Sticky violation interrupt |
| s_awid | input | IDW | Upstream write id |
| s_awaddr | input | AW | Upstream write address |
| s_awlen | input | 4 | Upstream burst length code |
| s_awsize | input | 3 | Upstream beat size code |
| s_awburst | input | 2 | Upstream burst type |
| s_awlock | input | 2 | Upstream lock code |
| s_awvalid | input | 1 | Upstream address valid |
| s_awready | output | 1 | Upstream address ready |
| s_wdata | input | DW | Upstream write data |
| s_wstrb | input | DW/8 | Upstream byte strobes |
| s_wlast | input | 1 | Upstream last beat |
| s_wvalid | input | 1 | Upstream data valid |
| s_wready | output | 1 | Upstream data ready |
| s_bid | output | IDW | Upstream response id |
| s_bresp | output | 2 | Upstream response code |
| s_bvalid | output | 1 | Upstream response valid |
| s_bready | input | 1 | Upstream response ready |
| m_awid | output | IDW | Downstream write id |
| m_awaddr | output | AW | Downstream write address |
| m_awlen | output | 4 | Downstream burst length code |
| m_awsize | output | 3 | Downstream beat size code |
| m_awburst | output | 2 | Downstream burst type |
| m_awlock | output | 2 | Downstream lock code |
| m_awvalid | output | 1 | Downstream address valid |
| m_awready | input | 1 | Downstream address ready |
| m_wdata | output | DW | Downstream write data |
| m_wstrb | output | DW/8 | Downstream byte strobes |
| m_wlast | output | 1 | Downstream last beat |
| m_wvalid | output | 1 | Downstream data valid |
| m_wready | input | 1 | Downstream data ready |
| m_bid | input | IDW | Downstream response id |
| m_bresp | input | 2 | Downstream response code |
| m_bvalid | input | 1 | Downstream response valid |
| m_bready | output | 1 | Downstream response ready |

## Verification
Some internal faults show up on the very response they belong to:
- A stale strobe accumulator or a misread geometry or lock attribute flips the response code of that burst, and also the interrupt one cycle after its last beat.
- A skewed verdict-slot pointer attaches a verdict to the wrong response, so an error appears on a neighbouring burst.

A wrong occupancy count only shows once four bursts are outstanding: either the fifth address is accepted, or the address channel never reopens.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  localparam logic [1:0] LOCK_EXCL   = 2'b01;
  localparam logic [1:0] LOCK_LOCKED = 2'b10;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef struct packed {
    logic geom;  // four-beat, full-width burst
    logic lock;  // exclusive or locked
  } aw_attr_t;
endpackage

// File: rtl/cwg_strobe_scan.sv
module cwg_strobe_scan #(
  parameter int SB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          last,
  input  logic [SB-1:0] strb,
  output logic          partial
);
  logic acc_q;
  logic this_partial;

  assign this_partial = (strb != {SB{1'b1}});
  assign partial      = acc_q | this_partial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               acc_q <= 1'b0;
    else if (beat && last)    acc_q <= 1'b0;
    else if (beat)            acc_q <= partial;
  end
endmodule

// File: rtl/cwg_track_fifo.sv
module cwg_track_fifo import cwg_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     push,
  input  aw_attr_t attr_in,
  input  logic     wdone,
  input  logic     partial,
  input  logic     pop,
  output logic     full,
  output logic     w_open,
  output logic     head_ready,
  output logic     head_bad,
  output logic     flag_set
);
  localparam int PW   = $clog2(DEPTH);
  localparam int PTRW = PW + 1;

  logic [PTRW-1:0] aw_ptr, w_ptr, b_ptr;
  aw_attr_t        attr_q [DEPTH];
  logic            bad_q  [DEPTH];
  aw_attr_t        w_attr;
  logic            verdict;

  assign full       = ((aw_ptr - b_ptr) == PTRW'(DEPTH));
  assign w_open     = (w_ptr != aw_ptr);
  assign head_ready = (b_ptr != w_ptr);
  assign head_bad   = bad_q[b_ptr[PW-1:0]];
  assign w_attr     = attr_q[w_ptr[PW-1:0]];
  assign verdict    = en && ((w_attr.geom && partial) || w_attr.lock);
  assign flag_set   = wdone && verdict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_ptr <= '0;
      w_ptr  <= '0;
      b_ptr  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        attr_q[i] <= '0;
        bad_q[i]  <= 1'b0;
      end
    end else begin
      if (push) begin
        attr_q[aw_ptr[PW-1:0]] <= attr_in;
        aw_ptr <= aw_ptr + 1'b1;
      end
      if (wdone) begin
        bad_q[w_ptr[PW-1:0]] <= verdict;
        w_ptr <= w_ptr + 1'b1;
      end
      if (pop) b_ptr <= b_ptr + 1'b1;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_ptr - b_ptr) <= PTRW'(DEPTH));
  // R10
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ptr - b_ptr) <= (aw_ptr - b_ptr));
  // R9
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/cwg_irq.sv
module cwg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> irq);
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !irq);
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);
endmodule

// File: rtl/coh_wr_guard.sv
module coh_wr_guard import cwg_pkg::*; #(
  parameter int IDW   = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int DEPTH = 4,
  parameter int BEATS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            det_en,
  input  logic            irq_clr,
  output logic            irq,
  input  logic [IDW-1:0]  s_awid,
  input  logic [AW-1:0]   s_awaddr,
  input  logic [3:0]      s_awlen,
  input  logic [2:0]      s_awsize,
  input  logic [1:0]      s_awburst,
  input  logic [1:0]      s_awlock,
  input  logic            s_awvalid,
  output logic            s_awready,
  input  logic [DW-1:0]   s_wdata,
  input  logic [DW/8-1:0] s_wstrb,
  input  logic            s_wlast,
  input  logic            s_wvalid,
  output logic            s_wready,
  output logic [IDW-1:0]  s_bid,
  output logic [1:0]      s_bresp,
  output logic            s_bvalid,
  input  logic            s_bready,
  output logic [IDW-1:0]  m_awid,
  output logic [AW-1:0]   m_awaddr,
  output logic [3:0]      m_awlen,
  output logic [2:0]      m_awsize,
  output logic [1:0]      m_awburst,
  output logic [1:0]      m_awlock,
  output logic            m_awvalid,
  input  logic            m_awready,
  output logic [DW-1:0]   m_wdata,
  output logic [DW/8-1:0] m_wstrb,
  output logic            m_wlast,
  output logic            m_wvalid,
  input  logic            m_wready,
  input  logic [IDW-1:0]  m_bid,
  input  logic [1:0]      m_bresp,
  input  logic            m_bvalid,
  output logic            m_bready
);
  localparam int SB        = DW / 8;
  localparam int SIZE_CODE = $clog2(SB);
  localparam int LEN_CODE  = BEATS - 1;

  logic     full, w_open, head_ready, head_bad, flag_set, partial;
  logic     aw_hs, w_hs, wdone, b_hs;
  aw_attr_t attr;

  // address channel: forwarded, stalled while the queue is full
  assign m_awid    = s_awid;
  assign m_awaddr  = s_awaddr;
  assign m_awlen   = s_awlen;
  assign m_awsize  = s_awsize;
  assign m_awburst = s_awburst;
  assign m_awlock  = s_awlock;
  assign m_awvalid = s_awvalid && !full;
  assign s_awready = m_awready && !full;
  assign aw_hs     = s_awvalid && s_awready;

  assign attr.geom = (s_awlen == 4'(LEN_CODE)) && (s_awsize == 3'(SIZE_CODE));
  assign attr.lock = (s_awlock == LOCK_EXCL) || (s_awlock == LOCK_LOCKED);

  // data channel: forwarded once the burst's address is known
  assign m_wdata  = s_wdata;
  assign m_wstrb  = s_wstrb;
  assign m_wlast  = s_wlast;
  assign m_wvalid = s_wvalid && w_open;
  assign s_wready = m_wready && w_open;
  assign w_hs     = s_wvalid && s_wready;
  assign wdone    = w_hs && s_wlast;

  // response channel: offered once the head burst has a verdict
  assign s_bid    = m_bid;
  assign s_bvalid = m_bvalid && head_ready;
  assign m_bready = s_bready && head_ready;
  assign s_bresp  = (det_en && head_bad) ? RESP_SLVERR : m_bresp;
  assign b_hs     = s_bvalid && s_bready;

  cwg_strobe_scan #(.SB(SB)) u_scan (
    .clk(clk), .rst_n(rst_n), .beat(w_hs), .last(s_wlast),
    .strb(s_wstrb), .partial(partial)
  );

  cwg_track_fifo #(.DEPTH(DEPTH)) u_track (
    .clk(clk), .rst_n(rst_n), .en(det_en), .push(aw_hs), .attr_in(attr),
    .wdone(wdone), .partial(partial), .pop(b_hs), .full(full),
    .w_open(w_open), .head_ready(head_ready), .head_bad(head_bad),
    .flag_set(flag_set)
  );

  cwg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(irq_clr), .irq(irq)
  );

  // R6
  disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !det_en) |-> (s_bresp == m_bresp));
  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && !irq) |=> !irq);
endmodule

// File: tb/coh_wr_guard_tb.sv
module coh_wr_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic det_en = 1'b1, irq_clr = 1'b0, irq;
  logic [3:0] s_awid = '0;  logic [31:0] s_awaddr = '0;
  logic [3:0] s_awlen = '0; logic [2:0] s_awsize = '0;
  logic [1:0] s_awburst = 2'b01, s_awlock = '0;
  logic s_awvalid = 1'b0, s_awready;
  logic [63:0] s_wdata = '0; logic [7:0] s_wstrb = '0;
  logic s_wlast = 1'b0, s_wvalid = 1'b0, s_wready;
  logic [3:0] s_bid; logic [1:0] s_bresp; logic s_bvalid, s_bready = 1'b1;
  logic [3:0] m_awid; logic [31:0] m_awaddr; logic [3:0] m_awlen;
  logic [2:0] m_awsize; logic [1:0] m_awburst, m_awlock;
  logic m_awvalid, m_awready = 1'b1;
  logic [63:0] m_wdata; logic [7:0] m_wstrb; logic m_wlast, m_wvalid, m_wready = 1'b1;
  logic [3:0] m_bid = '0; logic [1:0] m_bresp = '0; logic m_bvalid = 1'b0, m_bready;

  coh_wr_guard u_dut (.*);

  // downstream slave model
  logic [3:0] idq [8];
  int iw = 0, ir = 0, pend = 0;
  logic [1:0] slv_resp = 2'b00;
  always @(posedge clk) begin
    int inc, dec;
    inc = (m_wvalid && m_wready && m_wlast) ? 1 : 0;
    dec = (m_bvalid && m_bready) ? 1 : 0;
    if (m_awvalid && m_awready) begin idq[iw % 8] <= m_awid; iw <= iw + 1; end
    if (dec == 1) begin m_bvalid <= 1'b0; ir <= ir + 1; end
    else if (!m_bvalid && pend > 0) begin
      m_bvalid <= 1'b1; m_bid <= idq[ir % 8]; m_bresp <= slv_resp;
    end
    pend <= pend + inc - dec;
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_aw(input logic [3:0] id, input logic [3:0] len,
                       input logic [2:0] size, input logic [1:0] lock);
    bit rdy;
    s_awid = id; s_awaddr = {id, 20'h0, len, 4'h0}; s_awlen = len;
    s_awsize = size; s_awlock = lock; s_awvalid = 1'b1;
    #1;
    // R1 address fields forwarded unchanged
    chk({m_awid, m_awaddr, m_awlen, m_awsize, m_awburst, m_awlock} ==
        {s_awid, s_awaddr, s_awlen, s_awsize, s_awburst, s_awlock}, "R1 aw",
        m_awaddr, s_awaddr);
    forever begin
      rdy = s_awready;
      @(negedge clk);
      if (rdy) break;
      #1;
    end
    s_awvalid = 1'b0;
  endtask

  task automatic do_w(input int len, input int pidx, input bit clr_last);
    bit rdy;
    for (int b = 0; b <= len; b++) begin
      s_wvalid = 1'b1;
      s_wdata  = {32'(b * 7 + len), 32'(pidx + 100)};
      s_wstrb  = (b == pidx) ? ~(8'h01 << (b % 8)) : 8'hFF;
      s_wlast  = (b == len);
      irq_clr  = clr_last && (b == len);
      forever begin
        #1;
        rdy = s_wready;
        @(negedge clk);
        if (rdy) break;
      end
      irq_clr = 1'b0;
    end
    s_wvalid = 1'b0; s_wlast = 1'b0;
  endtask

  task automatic get_b(output logic [3:0] id, output logic [1:0] resp);
    forever begin
      #1;
      if (s_bvalid) begin id = s_bid; resp = s_bresp; @(negedge clk); break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] bid; logic [1:0] br;
    int idc;
    idc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(irq == 1'b0, "R7 reset irq", irq, 0);
    chk(s_awready == 1'b1, "R9 reset awready", s_awready, 1);
    chk(s_wready == 1'b0, "R10 reset wready", s_wready, 0);
    chk(s_bvalid == 1'b0, "R10 reset bvalid", s_bvalid, 0);
    @(negedge clk);

    // W beat before its address is held back
    s_wvalid = 1'b1; s_wstrb = 8'hFF; s_wlast = 1'b1; #1;
    chk(s_wready == 1'b0 && m_wvalid == 1'b0, "R10 w before aw", s_wready, 0);
    @(negedge clk); s_wvalid = 1'b0; s_wlast = 1'b0;

    // sweep over enable, length, size, lock, partial beat
    for (int en = 0; en < 2; en++)
      for (int len = 0; len < 5; len++)
        for (int size = 2; size < 4; size++)
          for (int lk = 0; lk < 3; lk++)
            for (int p = -1; p <= len; p++) begin
              bit geo, bad; logic [1:0] er; string tag; logic [3:0] id;
              id = 4'(idc); idc++;
              det_en = en[0];
              slv_resp = id[0] ? 2'b01 : 2'b00;
              geo = (len == 3) && (size == 3);
              bad = (geo && p >= 0) || lk == 1 || lk == 2;
              er  = (en == 1 && bad) ? 2'b10 : slv_resp;
              tag = (en == 0) ? "R6" : (lk != 0) ? "R4" : geo ? "R2" : "R3";
              do_aw(id, 4'(len), 3'(size), 2'(lk));
              do_w(len, p, 1'b0);
              #1;
              chk(m_wdata == s_wdata && m_wstrb == s_wstrb && m_wlast == s_wlast,
                  "R1 w", m_wdata, s_wdata);
              get_b(bid, br);
              chk(br == er, tag, br, er);
              chk(bid == id, "R5 bid", bid, id);
              #1;
              chk(irq == (en == 1 && bad), (en == 0) ? "R6 irq" : "R7 irq", irq, (en == 1 && bad));
              irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; #1;
              chk(irq == 1'b0, "R8 clear", irq, 0);
              @(negedge clk);
            end

    // clear in the same cycle as a flagged last beat: set wins
    det_en = 1'b1; slv_resp = 2'b00;
    do_aw(4'h3, 4'd3, 3'd3, 2'b00);
    do_w(3, 2, 1'b1);
    #1;
    chk(irq == 1'b1, "R8 set wins", irq, 1);
    get_b(bid, br);
    chk(br == 2'b10, "R2 set-wins burst", br, 2);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

    // fill the tracking queue
    for (int k = 0; k < 4; k++) do_aw(4'(k + 8), 4'd0, 3'd3, 2'b00);
    s_awvalid = 1'b1; s_awid = 4'hC; #1;
    chk(s_awready == 1'b0, "R9 full awready", s_awready, 0);
    chk(m_awvalid == 1'b0, "R9 full m_awvalid", m_awvalid, 0);
    repeat (3) @(negedge clk); #1;
    chk(s_awready == 1'b0, "R9 still full", s_awready, 0);
    @(negedge clk); s_awvalid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      do_w(0, -1, 1'b0);
      get_b(bid, br);
      chk(bid == 4'(k + 8) && br == 2'b00, "R5 queued order", bid, k + 8);
    end
    #1;
    chk(s_awready == 1'b1, "R9 drained", s_awready, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule